// File: doc/BRIEF.md
# Converter Serial Result Port

This block drives the serial data output of a successive-approximation converter. It offers two ways of reading the result, and both produce a 16-bit word with the most significant bit first. In the first, the host keeps the active-low select low through a conversion. Each bit then reaches the data line on the falling conversion-clock edge on which the sequencer reports its decision. In the second, the host reads a stored result between conversions with its own serial clock. That clock may run with no fixed relation to the conversion clock, at rates up to about 5 MHz.

A small state machine runs in the conversion-clock domain, clocked on the falling edge. Its states are EMPTY (no result since reset), LIVE (a conversion is in progress and decisions go straight to the line) and HOLD (a finished result is stored). It has three transitions: EMPTY to LIVE and HOLD to LIVE on a start strobe, and LIVE to HOLD on the done strobe. While the state is LIVE, a start strobe has no effect. Each falling edge of the select copies the stored word into a snapshot register. A bit pointer walks through that snapshot on falling serial-clock edges. Raising the select clears the pointer. The physical three-state pad sits outside this block: the block supplies the data value and an output-enable.

Top module: `adc_result_serializer`

## Requirements
- R1: While `cs_n` is high, `dout_en` is 0 and `dout` is 0. While `cs_n` is low, `dout_en` is 1.
- R2: When `cs_n` falls outside a conversion, `dout` shows bit 15 of the stored result before any serial-clock pulse.
- R3: In state LIVE with `cs_n` low, a cycle with `dec_valid` high puts `dec_bit` on `dout` at that falling conversion-clock edge, and it stays there until the next decision.
- R4: Each falling `sclk` edge with `cs_n` low moves to the next lower bit. After 15 pulses `dout` shows bit 0. The 16th and every later pulse give 0.
- R5: `conv_done` in state LIVE stores the 16 most recent decisions, first decided as bit 15. A decision given in the same cycle as the done strobe counts as bit 0. The state becomes HOLD and `dout` returns to the snapshot path.
- R6: A rising `cs_n` clears the bit pointer, even in the middle of a read, so the next read starts again at bit 15.
- R7: Every falling edge of `cs_n` reloads the snapshot from the stored result, so a result stored while `cs_n` was high is read in full on the next select.
- R8: After reset the state is EMPTY and the stored result is zero, so a read before any conversion gives all zeros.
- R9: `conv_start` moves the state from EMPTY or HOLD to LIVE. After the first conversion begins, the state never returns to EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Strobe from the sequencer: a conversion begins |
| dec_valid | input | 1 | A bit decision is presented this cycle |
| dec_bit | input | 1 | Value of the decided bit |
| conv_done | input | 1 | Strobe: conversion finished, store the result |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Host serial clock, asynchronous to `clk` |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Drive enable for the external pad |

## Verification
The bench sweeps walking-one words and dense patterns through full conversions. Each word is read both live and through the serial clock, with more pulses than the word has bits. A pointer that did not saturate would wrap round and repeat the MSB instead of giving zeros. An off-by-one in the bit select would put the LSB on the 16th pulse, not the 15th. The bench also raises the select in the middle of a read: a pointer that was not cleared would resume partway through the word. Conversions that deliver the last decision in the same cycle as the done strobe catch a capture that drops that bit. Watching `dout` just after done, with the select still low, shows whether the output path leaves the live bit.

// File: rtl/adc_result_serializer_pkg.sv
package adc_result_serializer_pkg;

    // Conversion-domain phases of the output port
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,   // no result stored since reset
        ST_LIVE  = 2'd1,   // conversion running, decisions go straight out
        ST_HOLD  = 2'd2    // finished result stored
    } ser_state_e;

endpackage

// File: rtl/adc_result_capture.sv
module adc_result_capture
    import adc_result_serializer_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             dec_valid,
    input  logic             dec_bit,
    input  logic             conv_done,
    output ser_state_e       st,
    output logic             live_q,
    output logic [RES_W-1:0] held_q
);

    ser_state_e       st_nx;
    logic [RES_W-1:0] asm_q;
    logic [RES_W-1:0] asm_next;

    // decision word including a bit offered this cycle
    always_comb begin
        if (dec_valid) begin
            asm_next = {asm_q[RES_W-2:0], dec_bit};
        end else begin
            asm_next = asm_q;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_EMPTY: if (conv_start) st_nx = ST_LIVE;
            ST_LIVE:  if (conv_done)  st_nx = ST_HOLD;
            ST_HOLD:  if (conv_start) st_nx = ST_LIVE;
            default:  st_nx = ST_EMPTY;
        endcase
    end

    // state register, falling conversion-clock edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_EMPTY;
        end else begin
            st <= st_nx;
        end
    end

    // datapath registers
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q  <= '0;
            live_q <= 1'b0;
            held_q <= '0;
        end else begin
            asm_q <= asm_next;
            if (dec_valid) begin
                live_q <= dec_bit;
            end
            if (st == ST_LIVE && conv_done) begin
                held_q <= asm_next;
            end
        end
    end

endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter #(
    parameter int RES_W = 16,
    localparam int PTR_W = $clog2(RES_W + 1)
) (
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] held_q,
    output logic             shift_bit,
    output logic [PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(RES_W);

    logic [RES_W-1:0] snap_q;
    logic [RES_W-1:0] shifted;
    logic             ptr_clr;

    // snapshot of the stored word on each select fall; held_q is quiet then
    always_ff @(negedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= held_q;
        end
    end

    assign ptr_clr = cs_n | ~rst_n;

    // bit pointer, advances on falling serial clock, saturates past the LSB
    always_ff @(negedge sclk or posedge ptr_clr) begin
        if (ptr_clr) begin
            ptr_q <= '0;
        end else if (ptr_q != PTR_END) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // shifting left by the pointer moves zeros in after the LSB
    always_comb begin
        shifted   = snap_q << ptr_q;
        shift_bit = shifted[RES_W-1];
    end

endmodule

// File: rtl/adc_result_serializer.sv
module adc_result_serializer
    import adc_result_serializer_pkg::*;
#(
    parameter int RES_W = 16,
    localparam int PTR_W = $clog2(RES_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic dec_valid,
    input  logic dec_bit,
    input  logic conv_done,
    input  logic cs_n,
    input  logic sclk,
    output logic dout,
    output logic dout_en
);

    ser_state_e       st;
    logic             live_q;
    logic [RES_W-1:0] held_q;
    logic             shift_bit;
    logic [PTR_W-1:0] ptr_q;

    adc_result_capture #(.RES_W(RES_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .dec_valid  (dec_valid),
        .dec_bit    (dec_bit),
        .conv_done  (conv_done),
        .st         (st),
        .live_q     (live_q),
        .held_q     (held_q)
    );

    adc_result_shifter #(.RES_W(RES_W)) u_shifter (
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .held_q     (held_q),
        .shift_bit  (shift_bit),
        .ptr_q      (ptr_q)
    );

    // output selection
    always_comb begin
        dout_en = ~cs_n;
        if (cs_n) begin
            dout = 1'b0;
        end else if (st == ST_LIVE) begin
            dout = live_q;
        end else begin
            dout = shift_bit;
        end
    end

endmodule

// File: rtl/adc_result_serializer_chk.sv
module adc_result_serializer_chk
    import adc_result_serializer_pkg::*;
#(
    parameter int RES_W = 16,
    localparam int PTR_W = $clog2(RES_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sclk,
    input logic             dec_valid,
    input logic             dec_bit,
    input logic             conv_done,
    input logic             dout,
    input logic             dout_en,
    input ser_state_e       st,
    input logic [PTR_W-1:0] ptr_q,
    input logic             shift_bit
);

    AST_QUIET_DESELECTED: assert property (@(negedge clk) disable iff (!rst_n)
        cs_n |-> (!dout && !dout_en)); // R1

    AST_LIVE_BIT_OUT: assert property (@(negedge clk) disable iff (!rst_n)
        (st == ST_LIVE && dec_valid && !conv_done && !cs_n)
        |=> (cs_n || dout == $past(dec_bit))); // R3

    AST_DONE_TO_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        (st == ST_LIVE && conv_done) |=> (st == ST_HOLD)); // R5

    AST_NO_RETURN_EMPTY: assert property (@(negedge clk) disable iff (!rst_n)
        (st != ST_EMPTY) |=> (st != ST_EMPTY)); // R9

    AST_ZERO_TAIL: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
        (ptr_q >= PTR_W'(RES_W)) |-> !shift_bit); // R4

endmodule

bind adc_result_serializer adc_result_serializer_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit),
    .conv_done (conv_done),
    .dout      (dout),
    .dout_en   (dout_en),
    .st        (st),
    .ptr_q     (ptr_q),
    .shift_bit (shift_bit)
);

// File: tb/adc_result_serializer_bench.sv
module adc_result_serializer_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic dec_valid = 1'b0;
    logic dec_bit = 1'b0;
    logic conv_done = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic dout;
    logic dout_en;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_result_serializer u_adc_result_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .dec_valid  (dec_valid),
        .dec_bit    (dec_bit),
        .conv_done  (conv_done),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one conversion: decisions MSB first; optionally done with the last bit
    task automatic run_conv(input logic [15:0] v, input bit done_last, input bit watch);
        @(posedge clk); #1 conv_start = 1'b1;
        @(posedge clk); #1 conv_start = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            dec_valid = 1'b1;
            dec_bit   = v[i];
            conv_done = done_last && (i == 0);
            @(posedge clk); #1;
            if (watch && !(done_last && i == 0))
                chk(dout == v[i], "R3 live bit", 32'(dout), 32'(v[i]));
        end
        dec_valid = 1'b0;
        conv_done = 1'b0;
        if (!done_last) begin
            conv_done = 1'b1;
            @(posedge clk); #1 conv_done = 1'b0;
        end
        @(posedge clk); #1;
    endtask

    // serial read with a given number of serial-clock pulses
    task automatic read_word(input logic [15:0] v, input int pulses, input string msb_tag);
        cs_n = 1'b0;
        #7;
        chk(dout_en == 1'b1, "R1 enable", 32'(dout_en), 32'd1);
        chk(dout == v[15], msb_tag, 32'(dout), 32'(v[15]));
        for (int k = 1; k <= pulses; k++) begin
            logic e;
            sclk = 1'b1; #10;
            sclk = 1'b0; #3;
            e = (k < 16) ? v[15-k] : 1'b0;
            chk(dout == e, (k < 16) ? "R4 shifted bit" : "R4 zero tail", 32'(dout), 32'(e));
            #7;
        end
        cs_n = 1'b1;
        #5;
        chk(!dout_en && !dout, "R1 quiet", {dout_en, dout}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [8];
        logic [15:0] prev;
        vals[0] = 16'hFFFF; vals[1] = 16'h0000; vals[2] = 16'hA5C3; vals[3] = 16'h8001;
        vals[4] = 16'h1234; vals[5] = 16'h7FFE; vals[6] = 16'h5A5A; vals[7] = 16'hC0DE;

        #1;
        chk(!dout_en && !dout, "R1 reset quiet", {dout_en, dout}, 32'd0);
        #20 rst_n = 1'b1;
        #10;
        // R8: empty store reads as zero
        read_word(16'h0000, 18, "R8 empty msb");

        prev = 16'h0000;
        for (int n = 0; n < 24; n++) begin
            logic [15:0] v;
            bit watch;
            v = (n < 16) ? (16'h0001 << n) : vals[n-16];
            watch = n[0];
            cs_n = watch ? 1'b0 : 1'b1;
            run_conv(v, n[1], watch);
            if (watch) begin
                // R5: back on the snapshot path showing the earlier word
                chk(dout == prev[15], "R5 snapshot path", 32'(dout), 32'(prev[15]));
            end
            cs_n = 1'b1;
            #5;
            // R7: a new select fall loads the fresh word
            read_word(v, 17, "R2 msb before sclk");
            prev = v;
        end

        // R6: abort a read midway and start again
        read_word(prev, 5, "R2 msb first read");
        read_word(prev, 16, "R6 restart at msb");

        // R9: conversion from HOLD, with done on the last bit
        cs_n = 1'b0;
        run_conv(16'h3C96, 1'b1, 1'b1);
        cs_n = 1'b1;
        #5;
        read_word(16'h3C96, 16, "R7 reload msb");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule